// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Unit

This unit holds the host-visible completion and error state of a flash controller. A command engine reports finished operations and failures as single-cycle pulses. The unit gathers them into an interrupt register and an error status register, and it drives an interrupt pin whose sense is set by a configuration bit. It also keeps two configuration words and drives a ready pin from one of them.

The host reaches the unit through a small register port. Reads return data one cycle after the request. A command written while the master interrupt bit is set is dropped. An accepted command is classified in three ways. A reset command restores the warm-reset state. A known command is handed to the engine as a one-cycle issue pulse. Any other code raises a command error. The unit does not carry out the commands.

Top module: `isr_top`

## Requirements
- R1: After the synchronous reset `rst`, the interrupt register reads 0x8080, status reads 0, config word A reads 0x40C0, config word B reads 0, `rdy_o` is 1 and `irq_o` is 1.
- R2: An event pulse sets its bit in the interrupt register in the next cycle: `ev_done_i[0]` (load) sets bit 7, `ev_done_i[1]` (program) sets bit 6, `ev_done_i[2]` (erase) sets bit 5. Every event, `ev_flag_i` included, also sets master bit 15.
- R3: Error pulses set status bits in the next cycle and also set master bit 15: `ev_err_i[0]` sets bit 10 (command), `ev_err_i[1]` sets bit 11 (erase), `ev_err_i[2]` sets bit 12 (program), `ev_err_i[3]` sets bit 13 (load).
- R4: A host write to the interrupt register (address 1) replaces it with its old value ANDed with the written data.
- R5: When bit 15 of the interrupt register is clear after an update, status bits 10 to 13 are cleared. While bit 15 stays set, those bits are kept.
- R6: `irq_o` equals interrupt bit 15 XOR the inverse of config A bit 6. With bit 6 at 1 the pin is active high; with bit 6 at 0 it is active low.
- R7: A write to the command register (address 4) while interrupt bit 15 is set has no effect: there is no issue pulse and the command readback is unchanged.
- R8: An accepted command code that is not known sets status bit 10 and interrupt bit 15. It gives no issue pulse, and the code can be read back.
- R9: An accepted known command gives a one-cycle `cmd_go_o` pulse in the next cycle, with `cmd_code_o` holding the code. The known codes are 0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0071, 0x0094, 0x0095, 0x00B0, 0x0030 and 0x0065.
- R10: An accepted command 0x00F0 or 0x00F3 applies warm reset: the interrupt register becomes 0x8010, status 0, config A 0x40C0, config B 0, the command register 0, and `rdy_o` 1.
- R11: Config A (address 2) reads back with its low 5 bits forced to 0. Config B (address 3) reads back as written. Status is at address 0.
- R12: Each write to config A sets `rdy_o` to the written bit 7 in the next cycle.
- R13: If an event pulse and a host AND-write to the interrupt register fall in the same cycle, the event bits survive the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register select: 0 status, 1 interrupt, 2 config A, 3 config B, 4 command |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data, valid the cycle after `host_re` |
| ev_done_i | input | 3 | Completion pulses: bit 0 load, bit 1 program, bit 2 erase |
| ev_flag_i | input | 1 | Pulse that sets only the master interrupt bit |
| ev_err_i | input | 4 | Error pulses: bit 0 command, 1 erase, 2 program, 3 load |
| cmd_go_o | output | 1 | One-cycle issue pulse for an accepted known command |
| cmd_code_o | output | 16 | Last accepted command code |
| irq_o | output | 1 | Interrupt pin, polarity set by config A bit 6 |
| rdy_o | output | 1 | Ready pin |

## Verification
The properties assume that event pulses last one cycle and that the engine raises no event in a cycle in which the host writes a command, since warm reset would then take priority over the event. Several properties also treat the unit's only reset source as `rst` or an accepted reset command. The stimulus drives each event for exactly one cycle, on cycles apart from host writes, except in the deliberate collision test of R13. The AND-mask property applies only to cycles with no event, which leaves the collision case to the bench.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int DW     = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_INT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFGA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFGB = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;

  localparam int B_MASTER = 15;
  localparam int B_LOAD   = 7;
  localparam int B_PROG   = 6;
  localparam int B_ERASE  = 5;
  localparam int B_CFG_POL = 6;
  localparam int B_CFG_RDY = 7;

  localparam int E_CMD   = 10;
  localparam int E_ERASE = 11;
  localparam int E_PROG  = 12;
  localparam int E_LOAD  = 13;

  localparam logic [DW-1:0] INT_COLD  = 16'h8080;
  localparam logic [DW-1:0] INT_WARM  = 16'h8010;
  localparam logic [DW-1:0] CFGA_INIT = 16'h40C0;
  localparam logic [DW-1:0] CFGA_RDMSK = 16'hFFE0;
  localparam logic [DW-1:0] ERR_BITS  = 16'h3C00;

  function automatic logic cmd_is_reset(input logic [DW-1:0] c);
    return (c == 16'h00F0) || (c == 16'h00F3);
  endfunction

  function automatic logic cmd_is_known(input logic [DW-1:0] c);
    case (c)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/isr_cmd_filter.sv
module isr_cmd_filter
  import isr_pkg::*;
(
  input  logic          wr_i,
  input  logic          busy_i,
  input  logic [DW-1:0] code_i,
  output logic          warm_o,
  output logic          known_o,
  output logic          unknown_o
);
  logic take;
  logic rst_cmd;
  logic kn_cmd;

  always_comb begin
    take      = wr_i && !busy_i;
    rst_cmd   = cmd_is_reset(code_i);
    kn_cmd    = cmd_is_known(code_i);
    warm_o    = take && rst_cmd;
    known_o   = take && !rst_cmd && kn_cmd;
    unknown_o = take && !rst_cmd && !kn_cmd;
  end
endmodule

// File: rtl/isr_event_regs.sv
module isr_event_regs
  import isr_pkg::*;
#(
  parameter int N_DONE = 3,
  parameter int N_ERR  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_i,
  input  logic              and_we_i,
  input  logic [DW-1:0]     and_mask_i,
  input  logic [N_DONE-1:0] done_i,
  input  logic              flag_i,
  input  logic [N_ERR-1:0]  err_i,
  input  logic              unk_i,
  output logic [DW-1:0]     int_q_o,
  output logic [DW-1:0]     stat_q_o,
  output logic [DW-1:0]     int_nxt_o
);
  localparam int DONE_POS [3] = '{B_LOAD, B_PROG, B_ERASE};
  localparam int ERR_POS  [4] = '{E_CMD, E_ERASE, E_PROG, E_LOAD};

  logic [DW-1:0] int_q, stat_q;
  logic [DW-1:0] set_v, err_v, masked, stat_keep, stat_nxt;

  always_comb begin
    set_v = '0;
    for (int i = 0; i < N_DONE; i++) set_v[DONE_POS[i]] = done_i[i];
    set_v[B_MASTER] = (|done_i) | flag_i | (|err_i) | unk_i;
    err_v = '0;
    for (int j = 0; j < N_ERR; j++) err_v[ERR_POS[j]] = err_i[j];
    err_v[E_CMD] = err_v[E_CMD] | unk_i;
    masked    = and_we_i ? (int_q & and_mask_i) : int_q;
    int_nxt_o = warm_i ? INT_WARM : (masked | set_v);
    stat_keep = int_nxt_o[B_MASTER] ? stat_q : (stat_q & ~ERR_BITS);
    stat_nxt  = warm_i ? '0 : (stat_keep | err_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else begin
      int_q  <= int_nxt_o;
      stat_q <= stat_nxt;
    end
  end

  assign int_q_o  = int_q;
  assign stat_q_o = stat_q;
endmodule

// File: rtl/isr_cfg_regs.sv
module isr_cfg_regs
  import isr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          warm_i,
  input  logic          wa_i,
  input  logic          wb_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfga_q_o,
  output logic [DW-1:0] cfgb_q_o,
  output logic [DW-1:0] cfga_nxt_o,
  output logic          rdy_o
);
  logic [DW-1:0] cfga_q, cfgb_q;
  logic          rdy_q;

  always_comb begin
    if (warm_i)    cfga_nxt_o = CFGA_INIT;
    else if (wa_i) cfga_nxt_o = wdata_i;
    else           cfga_nxt_o = cfga_q;
  end

  always_ff @(posedge clk) begin
    if (rst || warm_i) begin
      cfga_q <= CFGA_INIT;
      cfgb_q <= '0;
      rdy_q  <= 1'b1;
    end else begin
      cfga_q <= cfga_nxt_o;
      if (wb_i) cfgb_q <= wdata_i;
      if (wa_i) rdy_q <= wdata_i[B_CFG_RDY];
    end
  end

  assign cfga_q_o = cfga_q;
  assign cfgb_q_o = cfgb_q;
  assign rdy_o    = rdy_q;
endmodule

// File: rtl/isr_top.sv
module isr_top
  import isr_pkg::*;
#(
  parameter int N_DONE = 3,
  parameter int N_ERR  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [N_DONE-1:0] ev_done_i,
  input  logic              ev_flag_i,
  input  logic [N_ERR-1:0]  ev_err_i,
  output logic              cmd_go_o,
  output logic [DW-1:0]     cmd_code_o,
  output logic              irq_o,
  output logic              rdy_o
);
  logic          wr_int, wr_cfga, wr_cfgb, wr_cmd;
  logic          warm, known, unknown;
  logic [DW-1:0] int_q, stat_q, int_nxt;
  logic [DW-1:0] cfga_q, cfgb_q, cfga_nxt;
  logic [DW-1:0] cmd_q, rd_mux, rdata_q;
  logic          go_q, irq_q;

  assign wr_int  = host_we && (host_addr == A_INT);
  assign wr_cfga = host_we && (host_addr == A_CFGA);
  assign wr_cfgb = host_we && (host_addr == A_CFGB);
  assign wr_cmd  = host_we && (host_addr == A_CMD);

  isr_cmd_filter u_filt (
    .wr_i(wr_cmd), .busy_i(int_q[B_MASTER]), .code_i(host_wdata),
    .warm_o(warm), .known_o(known), .unknown_o(unknown)
  );

  isr_event_regs #(.N_DONE(N_DONE), .N_ERR(N_ERR)) u_evt (
    .clk(clk), .rst(rst), .warm_i(warm), .and_we_i(wr_int),
    .and_mask_i(host_wdata), .done_i(ev_done_i), .flag_i(ev_flag_i),
    .err_i(ev_err_i), .unk_i(unknown), .int_q_o(int_q),
    .stat_q_o(stat_q), .int_nxt_o(int_nxt)
  );

  isr_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .warm_i(warm), .wa_i(wr_cfga), .wb_i(wr_cfgb),
    .wdata_i(host_wdata), .cfga_q_o(cfga_q), .cfgb_q_o(cfgb_q),
    .cfga_nxt_o(cfga_nxt), .rdy_o(rdy_o)
  );

  always_comb begin
    case (host_addr)
      A_STAT:  rd_mux = stat_q;
      A_INT:   rd_mux = int_q;
      A_CFGA:  rd_mux = cfga_q & CFGA_RDMSK;
      A_CFGB:  rd_mux = cfgb_q;
      A_CMD:   rd_mux = cmd_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      go_q    <= 1'b0;
      irq_q   <= 1'b1;
      rdata_q <= '0;
    end else begin
      if (warm)                  cmd_q <= '0;
      else if (known || unknown) cmd_q <= host_wdata;
      go_q  <= known;
      irq_q <= int_nxt[B_MASTER] ^ ~cfga_nxt[B_CFG_POL];
      if (host_re) rdata_q <= rd_mux;
    end
  end

  assign host_rdata = rdata_q;
  assign cmd_go_o   = go_q;
  assign cmd_code_o = cmd_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/isr_top_chk.sv
module isr_top_chk
  import isr_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          host_we,
  input logic [2:0]    host_addr,
  input logic [DW-1:0] host_wdata,
  input logic [2:0]    ev_done_i,
  input logic          ev_flag_i,
  input logic [3:0]    ev_err_i,
  input logic [DW-1:0] int_q,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] cfga_q,
  input logic          cmd_go_o,
  input logic [DW-1:0] cmd_code_o,
  input logic          irq_o,
  input logic          rdy_o
);
  logic quiet;
  assign quiet = !(|ev_done_i) && !ev_flag_i && !(|ev_err_i);

  AST_COLD_VALUES: assert property (@(posedge clk)
    rst |=> (int_q == INT_COLD) && rdy_o && irq_o); // R1
  AST_EVENT_SETS_MASTER: assert property (@(posedge clk) disable iff (rst)
    (!host_we && !quiet) |=> int_q[B_MASTER]); // R2
  AST_AND_MASK: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == A_INT && quiet) |=> int_q == ($past(int_q) & $past(host_wdata))); // R4
  AST_ERR_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ERR_BITS) != '0) |-> int_q[B_MASTER]); // R5
  AST_IRQ_POLARITY: assert property (@(posedge clk) disable iff (rst)
    irq_o == (int_q[B_MASTER] ^ ~cfga_q[B_CFG_POL])); // R6
  AST_CMD_GATED: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == A_CMD && int_q[B_MASTER]) |=> !cmd_go_o && $stable(cmd_code_o)); // R7
  AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == A_CFGA) |=> rdy_o == $past(host_wdata[B_CFG_RDY])); // R12
endmodule

bind isr_top isr_top_chk u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .ev_done_i(ev_done_i), .ev_flag_i(ev_flag_i),
  .ev_err_i(ev_err_i), .int_q(int_q), .stat_q(stat_q), .cfga_q(cfga_q),
  .cmd_go_o(cmd_go_o), .cmd_code_o(cmd_code_o), .irq_o(irq_o), .rdy_o(rdy_o)
);

// File: tb/isr_top_tb.sv
module isr_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [2:0]  ev_done_i = '0;
  logic        ev_flag_i = 1'b0;
  logic [3:0]  ev_err_i = '0;
  logic        cmd_go_o, irq_o, rdy_o;
  logic [15:0] cmd_code_o;

  int checks = 0, failures = 0;
  logic done_run = 1'b0;
  logic rd_fire = 1'b0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  isr_top u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_done_i(ev_done_i), .ev_flag_i(ev_flag_i), .ev_err_i(ev_err_i),
    .cmd_go_o(cmd_go_o), .cmd_code_o(cmd_code_o), .irq_o(irq_o), .rdy_o(rdy_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_fire <= host_re;

  always @(negedge clk) begin
    if (rd_fire && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, host_rdata, e);
    end
  end

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    host_addr = a; host_re = 1'b1;
    @(negedge clk);
    host_re = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic ev(input logic [2:0] dn, input logic fl, input logic [3:0] er);
    ev_done_i = dn; ev_flag_i = fl; ev_err_i = er;
    @(negedge clk);
    ev_done_i = '0; ev_flag_i = 1'b0; ev_err_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", {15'd0, irq_o}, 16'd1);
    chk("R1 rdy", {15'd0, rdy_o}, 16'd1);
    rd(3'd1, 16'h8080, "R1 int");
    rd(3'd0, 16'h0000, "R1 status");
    rd(3'd2, 16'h40C0, "R1 cfgA");
    rd(3'd3, 16'h0000, "R1 cfgB");

    wr(3'd4, 16'h0080);
    chk("R7 go while busy", {15'd0, cmd_go_o}, 16'd0);
    rd(3'd4, 16'h0000, "R7 cmd unchanged");

    wr(3'd1, 16'h0000);
    chk("R6 irq low", {15'd0, irq_o}, 16'd0);
    rd(3'd1, 16'h0000, "R4 cleared");

    wr(3'd4, 16'h0080);
    chk("R9 go", {15'd0, cmd_go_o}, 16'd1);
    chk("R9 code", cmd_code_o, 16'h0080);
    @(negedge clk);
    chk("R9 go one cycle", {15'd0, cmd_go_o}, 16'd0);

    ev(3'b010, 1'b0, 4'b0000);
    chk("R6 irq high", {15'd0, irq_o}, 16'd1);
    rd(3'd1, 16'h8040, "R2 prog done");
    wr(3'd1, 16'hFFBF);
    rd(3'd1, 16'h8000, "R4 and mask");
    wr(3'd1, 16'h7FFF);
    rd(3'd1, 16'h0000, "R4 master clear");

    ev(3'b010, 1'b0, 4'b0100);
    rd(3'd0, 16'h1000, "R3 prog error");
    rd(3'd1, 16'h8040, "R3 master set");
    wr(3'd1, 16'hFFFF);
    rd(3'd0, 16'h1000, "R5 errors kept");
    wr(3'd1, 16'h7FFF);
    rd(3'd0, 16'h0000, "R5 errors wiped");
    rd(3'd1, 16'h0040, "R5 int left");

    ev(3'b000, 1'b0, 4'b1001);
    rd(3'd0, 16'h2400, "R3 load+cmd error");
    wr(3'd1, 16'h0000);

    wr(3'd4, 16'h0055);
    chk("R8 no go", {15'd0, cmd_go_o}, 16'd0);
    rd(3'd0, 16'h0400, "R8 cmd error");
    rd(3'd1, 16'h8000, "R8 master");
    rd(3'd4, 16'h0055, "R8 code readback");
    wr(3'd1, 16'h0000);

    wr(3'd2, 16'h0000);
    chk("R12 rdy low", {15'd0, rdy_o}, 16'd0);
    chk("R6 active low idle", {15'd0, irq_o}, 16'd1);
    wr(3'd2, 16'h00BF);
    chk("R12 rdy high", {15'd0, rdy_o}, 16'd1);
    rd(3'd2, 16'h00A0, "R11 cfgA mask");
    wr(3'd3, 16'h1234);
    rd(3'd3, 16'h1234, "R11 cfgB");

    ev(3'b001, 1'b0, 4'b0000);
    chk("R6 active low asserted", {15'd0, irq_o}, 16'd0);
    rd(3'd1, 16'h8080, "R2 load done");

    host_addr = 3'd1; host_wdata = 16'h0000; host_we = 1'b1; ev_done_i = 3'b100;
    @(negedge clk);
    host_we = 1'b0; ev_done_i = '0;
    rd(3'd1, 16'h8020, "R13 event beats mask");

    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0000);
    chk("R12 rdy before warm", {15'd0, rdy_o}, 16'd0);
    wr(3'd4, 16'h00F3);
    chk("R10 no go", {15'd0, cmd_go_o}, 16'd0);
    chk("R10 rdy", {15'd0, rdy_o}, 16'd1);
    chk("R10 irq", {15'd0, irq_o}, 16'd1);
    rd(3'd1, 16'h8010, "R10 int");
    rd(3'd2, 16'h40C0, "R10 cfgA");
    rd(3'd3, 16'h0000, "R10 cfgB");
    rd(3'd4, 16'h0000, "R10 cmd");
    rd(3'd0, 16'h0000, "R10 status");

    wr(3'd1, 16'h0000);
    ev(3'b000, 1'b1, 4'b0000);
    rd(3'd1, 16'h8000, "R2 flag only");

    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h00F0);
    rd(3'd1, 16'h8010, "R10 second reset code");

    repeat (2) @(negedge clk);
    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule